// File: doc/BRIEF.md
# Rate-Scaled Bit Clock and Timeout Generator

This block turns a counting clock into a bit-rate tick. A programmable power-of-two prescaler sets the tick rate. The block also runs one protocol timeout at a time, and its length is given in bit times rather than clock cycles. The timer advances only on bit ticks, so a single terminal count gives the right duration at every supported data rate (10 Mbps down to 156.25 Kbps). An idle-line window of 205 bit times works out to 20.5 µs at the top rate and about 1.3 ms at the slowest.

The block reads two configuration inputs on every cycle: the internal-clock setting (80, 40 or 20 MHz) and the prescaler setting. When it sees a legal pair that differs from the one it holds, it adopts the new pair. It then restarts the prescaler and drops any timeout that is running. An illegal pair has no effect. The combined power-of-two stretch factor is reported as a shift amount. A start strobe with a timer select launches or relaunches a timeout. Expiry gives a one-cycle pulse, plus an extra flag when the idle-line timer is the one that expired.

Top module: `rate_timer`

## Requirements
- R1: Reset (synchronous, active high) selects internal clock 80 MHz with divide-by-8, so scale_shift is 0. bit_tick, tmo_pulse and idle_tmo are low.
- R2: bit_tick is a one-cycle pulse that repeats every 8<<pre_sel clock cycles. pre_sel encodes 0=÷8, 1=÷16, 2=÷32, 3=÷64, 4=÷128.
- R3: clk_sel encodes 0=80 MHz, 1=40 MHz, 2=20 MHz. Only these pairs are legal: (0,0), (1,0), and (2,0..4). Any other pair leaves the held configuration, the tick period and scale_shift unchanged.
- R4: scale_shift equals clk_sel+pre_sel of the held configuration. This gives timeout factors 1 to 64, and the value never exceeds 6.
- R5: A started timeout counts bit ticks. The terminal counts are set by tmr_sel: 0=idle line (205 by default), 1=TC_RESP, 2=TC_LONG, 3=TC_AUX. When the prescaler has just been restarted and the start follows two cycles after the configuration change, tmo_pulse appears exactly count×(8<<pre_sel) cycles after the start edge.
- R6: tmo_pulse lasts one cycle. Without a new start it never fires again.
- R7: A start strobe while a timeout is running reloads it from zero with the newly selected terminal count.
- R8: Adopting a new configuration restarts the prescaler and cancels a running timeout. In the cycle after the change, bit_tick and tmo_pulse are low.
- R9: idle_tmo pulses together with tmo_pulse, and only when the expiring timer is select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (models the internal clock) |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Internal clock setting: 0=80, 1=40, 2=20 MHz |
| pre_sel | input | 3 | Prescaler setting: divide by 8<<pre_sel |
| tmr_start | input | 1 | Start/restart strobe for the timeout |
| tmr_sel | input | 2 | Which terminal count the started timeout uses |
| bit_tick | output | 1 | One-cycle bit-rate enable |
| tmo_pulse | output | 1 | One-cycle timeout expiry |
| idle_tmo | output | 1 | Expiry of the idle-line timer |
| scale_shift | output | 3 | log2 of the timeout stretch factor |

## Verification
The bench keeps the default idle count of 205. It sets the other terminal counts to 4, 17 and 1. The count of 1 reaches the corner where expiry follows the very first tick after the start. The long idle count is run at both ends of the rate range, so the bench sees the full 64-fold stretch (26,240 cycles). The smaller counts keep the restart and cancel cases short enough to check each boundary exactly.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int BASE_DIV = 8;
  localparam int MAX_PRE  = 4;
  localparam int CKW      = 2;
  localparam int PRW      = 3;
  localparam int SHW      = 3;

  function automatic logic cfg_ok(input logic [CKW-1:0] ck, input logic [PRW-1:0] pre);
    case (ck)
      2'd0, 2'd1: cfg_ok = (pre == '0);
      2'd2:       cfg_ok = (pre <= PRW'(MAX_PRE));
      default:    cfg_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rt_cfg.sv
module rt_cfg
  import rt_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [CKW-1:0] ck_in,
  input  logic [PRW-1:0] pre_in,
  output logic [CKW-1:0] ck_q,
  output logic [PRW-1:0] pre_q,
  output logic [SHW-1:0] shift_q,
  output logic           chg_q
);
  logic take;
  assign take = cfg_ok(ck_in, pre_in) && ((ck_in != ck_q) || (pre_in != pre_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q    <= '0;
      pre_q   <= '0;
      shift_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= take;
      if (take) begin
        ck_q    <= ck_in;
        pre_q   <= pre_in;
        shift_q <= SHW'(ck_in) + SHW'(pre_in);
      end
    end
  end
endmodule

// File: rtl/rt_prescale.sv
module rt_prescale
  import rt_pkg::*;
#(
  parameter int BDIV = BASE_DIV,
  parameter int MPRE = MAX_PRE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [PRW-1:0] pre,
  output logic           tick
);
  localparam int MAXDIV = BDIV << MPRE;
  localparam int CW     = $clog2(MAXDIV);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'((BDIV << pre) - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rt_timeout.sv
module rt_timeout #(
  parameter int NT = 4,
  parameter int TCW = 8,
  parameter logic [NT*TCW-1:0] TC_VEC = '1,
  parameter int IDLE_SEL = 0,
  localparam int SW = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          tick,
  input  logic          start,
  input  logic [SW-1:0] sel,
  output logic          pulse,
  output logic          idle_pulse
);
  logic [TCW-1:0] tcs [NT];
  logic [TCW-1:0] cnt;
  logic [SW-1:0]  sel_q;
  logic           run;

  for (genvar i = 0; i < NT; i++) begin : g_tc
    assign tcs[i] = TC_VEC[i*TCW +: TCW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      cnt        <= '0;
      sel_q      <= '0;
      pulse      <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      pulse      <= 1'b0;
      idle_pulse <= 1'b0;
      if (abort) begin
        run <= 1'b0;
      end else if (start) begin
        run   <= 1'b1;
        cnt   <= '0;
        sel_q <= sel;
      end else if (run && tick) begin
        if (cnt == tcs[sel_q] - 1'b1) begin
          run        <= 1'b0;
          pulse      <= 1'b1;
          idle_pulse <= (sel_q == SW'(IDLE_SEL));
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rate_timer.sv
module rate_timer
  import rt_pkg::*;
#(
  parameter int TCW = 8,
  parameter logic [TCW-1:0] TC_IDLE = 8'd205,
  parameter logic [TCW-1:0] TC_RESP = 8'd4,
  parameter logic [TCW-1:0] TC_LONG = 8'd17,
  parameter logic [TCW-1:0] TC_AUX  = 8'd1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     clk_sel,
  input  logic [2:0]     pre_sel,
  input  logic           tmr_start,
  input  logic [1:0]     tmr_sel,
  output logic           bit_tick,
  output logic           tmo_pulse,
  output logic           idle_tmo,
  output logic [2:0]     scale_shift
);
  localparam int NT = 4;
  localparam logic [NT*TCW-1:0] TC_VEC = {TC_AUX, TC_LONG, TC_RESP, TC_IDLE};

  logic [CKW-1:0] ck_q;
  logic [PRW-1:0] pre_q;
  logic           chg;

  rt_cfg u_cfg (
    .clk(clk), .rst(rst), .ck_in(clk_sel), .pre_in(pre_sel),
    .ck_q(ck_q), .pre_q(pre_q), .shift_q(scale_shift), .chg_q(chg)
  );

  rt_prescale #(.BDIV(BASE_DIV), .MPRE(MAX_PRE)) u_pre (
    .clk(clk), .rst(rst), .clr(chg), .pre(pre_q), .tick(bit_tick)
  );

  rt_timeout #(.NT(NT), .TCW(TCW), .TC_VEC(TC_VEC), .IDLE_SEL(0)) u_tmo (
    .clk(clk), .rst(rst), .abort(chg), .tick(bit_tick),
    .start(tmr_start), .sel(tmr_sel), .pulse(tmo_pulse), .idle_pulse(idle_tmo)
  );

  logic unused_ck;
  assign unused_ck = ^ck_q;
endmodule

// File: rtl/rate_timer_chk.sv
module rate_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] clk_sel,
  input logic [2:0] pre_sel,
  input logic       bit_tick,
  input logic       tmo_pulse,
  input logic       idle_tmo,
  input logic [2:0] scale_shift
);
  logic legal;
  assign legal = ((clk_sel == 2'd0) && (pre_sel == 3'd0)) ||
                 ((clk_sel == 2'd1) && (pre_sel == 3'd0)) ||
                 ((clk_sel == 2'd2) && (pre_sel <= 3'd4));

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst) tmo_pulse |=> !tmo_pulse);
  // R9
  idle_sub_chk: assert property (@(posedge clk) disable iff (rst) idle_tmo |-> tmo_pulse);
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst) bit_tick |=> !bit_tick);
  // R3
  bad_cfg_chk: assert property (@(posedge clk) disable iff (rst) !legal |=> $stable(scale_shift));
  // R4
  shift_max_chk: assert property (@(posedge clk) disable iff (rst) scale_shift <= 3'd6);
  // R8
  cfg_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(scale_shift) |=> (!bit_tick && !tmo_pulse));
endmodule

bind rate_timer rate_timer_chk u_chk (
  .clk(clk), .rst(rst), .clk_sel(clk_sel), .pre_sel(pre_sel),
  .bit_tick(bit_tick), .tmo_pulse(tmo_pulse), .idle_tmo(idle_tmo),
  .scale_shift(scale_shift)
);

// File: tb/sim_rate_timer.sv
`timescale 1ns/1ps
module sim_rate_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] clk_sel = 2'd0;
  logic [2:0] pre_sel = 3'd0;
  logic       tmr_start = 1'b0;
  logic [1:0] tmr_sel = 2'd0;
  logic       bit_tick, tmo_pulse, idle_tmo;
  logic [2:0] scale_shift;

  int n_chk = 0;
  int n_bad = 0;
  int tcs[4] = '{205, 4, 17, 1};

  always #2 clk = ~clk;

  rate_timer #(.TCW(8), .TC_IDLE(8'd205), .TC_RESP(8'd4), .TC_LONG(8'd17), .TC_AUX(8'd1)) u0 (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .pre_sel(pre_sel),
    .tmr_start(tmr_start), .tmr_sel(tmr_sel), .bit_tick(bit_tick),
    .tmo_pulse(tmo_pulse), .idle_tmo(idle_tmo), .scale_shift(scale_shift)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legal(input int c, input int p);
    return (c == 0 && p == 0) || (c == 1 && p == 0) || (c == 2 && p >= 0 && p <= 4);
  endfunction

  // behavioural reference, one step per clock
  int mc, mp, mchg, mpc, mtick, mrun, mtc, mts, mpulse, midle;
  always @(posedge clk) begin
    int nc, np, nchg, npc, ntick, nrun, ntc, nts, npulse, nidle, dv;
    if (rst) begin
      mc = 0; mp = 0; mchg = 0; mpc = 0; mtick = 0;
      mrun = 0; mtc = 0; mts = 0; mpulse = 0; midle = 0;
    end else begin
      nc = mc; np = mp; nchg = 0;
      if (legal(clk_sel, pre_sel) && (clk_sel != mc || pre_sel != mp)) begin
        nc = clk_sel; np = pre_sel; nchg = 1;
      end
      dv = 8 << mp;
      if (mchg != 0) begin npc = 0; ntick = 0; end
      else if (mpc == dv - 1) begin npc = 0; ntick = 1; end
      else begin npc = mpc + 1; ntick = 0; end
      npulse = 0; nidle = 0; nrun = mrun; ntc = mtc; nts = mts;
      if (mchg != 0) nrun = 0;
      else if (tmr_start) begin nrun = 1; ntc = 0; nts = tmr_sel; end
      else if (mrun != 0 && mtick != 0) begin
        if (mtc == tcs[mts] - 1) begin nrun = 0; npulse = 1; nidle = (mts == 0); end
        else ntc = mtc + 1;
      end
      mc = nc; mp = np; mchg = nchg; mpc = npc; mtick = ntick;
      mrun = nrun; mtc = ntc; mts = nts; mpulse = npulse; midle = nidle;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(bit_tick == mtick[0], "R2 tick vs model", bit_tick, mtick);
      check(tmo_pulse == mpulse[0], "R5 expiry vs model", tmo_pulse, mpulse);
      check(idle_tmo == midle[0], "R9 idle flag vs model", idle_tmo, midle);
      check(int'(scale_shift) == mc + mp, "R4 scale vs model", scale_shift, mc + mp);
    end
  end

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic tchk(input int c, input int p, input int s);
    int n, dv;
    dv = 8 << p;
    @(negedge clk); clk_sel = 2'(c); pre_sel = 3'(p);
    @(negedge clk);
    @(negedge clk); tmr_start = 1'b1; tmr_sel = 2'(s);
    @(negedge clk); tmr_start = 1'b0; n = 0;
    while (!tmo_pulse && n < 40000) begin @(negedge clk); n++; end
    check(n == tcs[s] * dv, "R5 expiry latency", n, tcs[s] * dv);
    check(idle_tmo == (s == 0), "R9 idle flag at expiry", idle_tmo, s == 0);
    n = 0;
    for (int k = 0; k < 3 * dv; k++) begin @(negedge clk); if (tmo_pulse) n++; end
    check(n == 0, "R6 no retrigger", n, 0);
  endtask

  task automatic period(input int exp, input string req);
    int n;
    n = 0;
    while (!bit_tick && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    @(negedge clk); n = 1;
    while (!bit_tick && n < 1000) begin @(negedge clk); n++; end
    check(n == exp, req, n, exp);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(scale_shift == 3'd0 && !bit_tick && !tmo_pulse && !idle_tmo, "R1 reset state", scale_shift, 0);
    rst = 1'b0;
    @(negedge clk);
    check(scale_shift == 3'd0, "R1 default scale", scale_shift, 0);
    tchk(1, 0, 1);
    check(scale_shift == 3'd1, "R4 40MHz factor", scale_shift, 1);
    tchk(2, 2, 2);
    check(scale_shift == 3'd4, "R4 20MHz div32 factor", scale_shift, 4);
    tchk(2, 0, 3);
    tchk(0, 0, 0);
    tchk(2, 4, 0);
    check(scale_shift == 3'd6, "R4 slowest factor", scale_shift, 6);
    period(128, "R2 period div128");
    @(negedge clk); clk_sel = 2'd2; pre_sel = 3'd1;
    period(16, "R2 period div16");
    // illegal pairs
    @(negedge clk); clk_sel = 2'd0; pre_sel = 3'd3;
    repeat (2) @(negedge clk);
    check(scale_shift == 3'd3, "R3 illegal 80MHz/div64 ignored", scale_shift, 3);
    period(16, "R3 period kept");
    @(negedge clk); clk_sel = 2'd3; pre_sel = 3'd0;
    repeat (2) @(negedge clk);
    check(scale_shift == 3'd3, "R3 illegal clock code ignored", scale_shift, 3);
    @(negedge clk); clk_sel = 2'd2; pre_sel = 3'd5;
    repeat (2) @(negedge clk);
    check(scale_shift == 3'd3, "R3 illegal divider ignored", scale_shift, 3);
    period(16, "R3 period kept after bad divider");
    // restart
    @(negedge clk); clk_sel = 2'd1; pre_sel = 3'd0;
    repeat (3) @(negedge clk);
    tmr_start = 1'b1; tmr_sel = 2'd1;
    @(negedge clk); tmr_start = 1'b0;
    repeat (19) @(negedge clk);
    tmr_start = 1'b1; tmr_sel = 2'd1;
    @(negedge clk); tmr_start = 1'b0; n = 0;
    while (!tmo_pulse && n < 1000) begin @(negedge clk); n++; end
    check(n > 24 && n <= 32, "R7 restart reloads count", n, 32);
    // abort by configuration change
    @(negedge clk); tmr_start = 1'b1; tmr_sel = 2'd2;
    @(negedge clk); tmr_start = 1'b0;
    repeat (50) @(negedge clk);
    clk_sel = 2'd2; pre_sel = 3'd0;
    n = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (tmo_pulse) n++; end
    check(n == 0, "R8 change cancels timeout", n, 0);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule